// File: doc/BRIEF.md
# SPI Serial Clock Prescaler

This block derives the serial clock of an SPI master from the system clock and shapes it for one frame at a time. The rate comes from three stages in series: a fixed divide-by-two, a divide-by-sixteen stage that can be switched in, and a programmable modulus of `rate_mod + 1`, where `rate_mod` is 4 bits wide. The resulting serial clock toggles every `2 * (slow ? 16 : 1) * (rate_mod + 1)` system clocks. Its frequency is therefore `fsys / 2 / ((rate_mod+1) * 2 * (slow ? 16 : 1))`.

While `frame_active` is low the serial clock rests at the level chosen by `cfg_cpol`. When a frame opens, the block captures the polarity, phase, slow-stage and modulus settings. It restarts every divider stage from zero, so the first serial clock edge always falls a fixed number of cycles after the frame opens. Alongside the clock, the block emits one-cycle launch and capture strobes in the system clock domain, so a shift register can drive out and sample data on the edges that `cfg_cpha` selects. Every output is registered.

Top module: `spi_sck_gen`

## Requirements
- R1: During reset and on the first cycle after it, `sck`, `launch_stb` and `capture_stb` are all 0.
- R2: While `frame_active` is low, `sck` equals the `cfg_cpol` value that was sampled on the previous clock edge, and both strobes are 0.
- R3: With `cfg_slow`=0, the first rising clock edge that samples `frame_active`=1 opens a frame; call it edge 0. `sck` toggles at edges N*2*(`rate_mod`+1), for N = 1, 2, ..., and holds its value between those edges.
- R4: With `cfg_slow`=1, `sck` toggles every 32*(`rate_mod`+1) clock edges, counted from the edge that opens the frame.
- R5: Both extreme modulus values give the rates of R3 and R4: `rate_mod`=0 (half period 2 or 32 cycles) and `rate_mod`=15 (half period 32 or 512 cycles).
- R6: With `cfg_cpha`=0, `launch_stb` pulses at the edge that opens the frame. After that, `capture_stb` pulses at the odd-numbered (leading) toggles of `sck` and `launch_stb` pulses at the even-numbered (trailing) toggles.
- R7: With `cfg_cpha`=1, no strobe pulses when the frame opens. `launch_stb` pulses at the leading toggles and `capture_stb` pulses at the trailing toggles.
- R8: Changes to `cfg_cpol`, `cfg_cpha`, `cfg_slow` or `rate_mod` while a frame is open have no effect on `sck` or the strobes until the next frame opens. The next frame uses the new values.
- R9: When `frame_active` drops in the middle of a half period, `sck` returns to idle on the next edge. The following frame restarts phase-aligned, with its first toggle a full half period after it opens.
- R10: Each strobe is high for exactly one cycle at a time, and `launch_stb` and `capture_stb` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_active | input | 1 | High for as long as a frame is in progress |
| cfg_cpol | input | 1 | Idle level of `sck` |
| cfg_cpha | input | 1 | 0: capture on leading edges; 1: launch on leading edges |
| cfg_slow | input | 1 | Switches in the extra divide-by-16 stage |
| rate_mod | input | MOD_W (4) | Modulus setting; the divide ratio is `rate_mod`+1 |
| sck | output | 1 | Serial clock |
| launch_stb | output | 1 | One-cycle pulse on the edges where data is driven out |
| capture_stb | output | 1 | One-cycle pulse on the edges where data is sampled |

## Verification
Every output comes from a single register that is loaded on the edge where the inputs are sampled. A change of `frame_active` or of the configuration therefore appears one clock later, and a scheduled `sck` edge appears at exactly edge N*half after the opening edge, together with its strobe. The bench drives inputs on falling edges. A behavioural model advances on each rising edge from the same sampled inputs, and the registered outputs are compared against the model on the falling edge that follows. Every cycle is checked, so a toggle that arrives one cycle early or late, or a strobe on the wrong edge, shows up as a miscompare at that cycle.

// File: rtl/sckp_pkg.sv
package sckp_pkg;

  typedef enum logic [1:0] {
    ROLE_NONE    = 2'd0,
    ROLE_LAUNCH  = 2'd1,
    ROLE_CAPTURE = 2'd2
  } edge_role_e;

  typedef struct packed {
    logic cpol;
    logic cpha;
    logic slow;
  } frame_mode_t;

  // Role of an sck toggle: leading edges capture when cpha=0, launch when cpha=1.
  function automatic edge_role_e toggle_role(input logic leading, input logic cpha);
    return (leading ^ cpha) ? ROLE_CAPTURE : ROLE_LAUNCH;
  endfunction

endpackage

// File: rtl/sckp_rate_chain.sv
module sckp_rate_chain #(
  parameter int unsigned MOD_W    = 4,
  parameter int unsigned SLOW_DIV = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             advance,
  input  logic             slow,
  input  logic [MOD_W-1:0] mod_lim,
  output logic             edge_due
);
  localparam int unsigned SLOW_W = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
  localparam logic [SLOW_W-1:0] SLOW_LAST = SLOW_W'(SLOW_DIV - 1);

  logic             half_q;
  logic             tick_half;
  logic             tick_slow;
  logic [MOD_W-1:0] mod_cnt;

  // Fixed divide-by-two stage
  always_ff @(posedge clk) begin
    if (rst || clear)  half_q <= 1'b0;
    else if (advance)  half_q <= ~half_q;
  end
  assign tick_half = advance & half_q;

  // Optional divide stage
  generate
    if (SLOW_DIV > 1) begin : g_slow
      logic [SLOW_W-1:0] slow_cnt;
      always_ff @(posedge clk) begin
        if (rst || clear) begin
          slow_cnt <= '0;
        end else if (tick_half && slow) begin
          if (slow_cnt == SLOW_LAST) slow_cnt <= '0;
          else                       slow_cnt <= slow_cnt + 1'b1;
        end
      end
      assign tick_slow = slow ? (tick_half && slow_cnt == SLOW_LAST) : tick_half;
    end else begin : g_no_slow
      assign tick_slow = tick_half;
    end
  endgenerate

  // Programmable modulus stage
  always_ff @(posedge clk) begin
    if (rst || clear) begin
      mod_cnt <= '0;
    end else if (tick_slow) begin
      if (mod_cnt == mod_lim) mod_cnt <= '0;
      else                    mod_cnt <= mod_cnt + 1'b1;
    end
  end
  assign edge_due = tick_slow && (mod_cnt == mod_lim);

  // R3/R4: modulus counter never passes the latched limit
  assert_mod_in_range_R3: assert property (@(posedge clk) disable iff (rst)
    mod_cnt <= mod_lim);

  // R9: a clear always brings the chain back to its start
  assert_clear_restarts_R9: assert property (@(posedge clk) disable iff (rst)
    clear |=> (mod_cnt == '0 && !half_q));

endmodule

// File: rtl/sckp_edge_seq.sv
module sckp_edge_seq
  import sckp_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        frame_active,
  input  frame_mode_t mode_in,
  input  logic        edge_due,
  output logic        frame_start,
  output logic        running,
  output logic        sck,
  output logic        launch_stb,
  output logic        capture_stb
);
  logic        run_q;
  logic        lead_next_q;
  frame_mode_t mode_q;
  logic        sck_q;
  logic        launch_q;
  logic        capture_q;
  edge_role_e  role;

  assign frame_start = frame_active & ~run_q;
  assign running     = run_q;
  assign role        = toggle_role(lead_next_q, mode_q.cpha);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q       <= 1'b0;
      lead_next_q <= 1'b1;
      mode_q      <= '0;
      sck_q       <= 1'b0;
      launch_q    <= 1'b0;
      capture_q   <= 1'b0;
    end else if (!frame_active) begin
      run_q       <= 1'b0;
      lead_next_q <= 1'b1;
      sck_q       <= mode_in.cpol;
      launch_q    <= 1'b0;
      capture_q   <= 1'b0;
    end else if (frame_start) begin
      run_q       <= 1'b1;
      lead_next_q <= 1'b1;
      mode_q      <= mode_in;
      sck_q       <= mode_in.cpol;
      launch_q    <= ~mode_in.cpha;
      capture_q   <= 1'b0;
    end else begin
      launch_q  <= 1'b0;
      capture_q <= 1'b0;
      if (edge_due) begin
        sck_q       <= ~sck_q;
        lead_next_q <= ~lead_next_q;
        launch_q    <= (role == ROLE_LAUNCH);
        capture_q   <= (role == ROLE_CAPTURE);
      end
    end
  end

  assign sck         = sck_q;
  assign launch_stb  = launch_q;
  assign capture_stb = capture_q;

  // R10: strobes are mutually exclusive
  assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (rst)
    !(launch_q && capture_q));

  // R10: no strobe is held for two cycles
  assert_strobe_single_R10: assert property (@(posedge clk) disable iff (rst)
    (launch_q || capture_q) |=> !(launch_q || capture_q));

  // R2: idle level follows polarity one cycle later
  assert_idle_level_R2: assert property (@(posedge clk) disable iff (rst)
    !frame_active |=> (sck_q == $past(mode_in.cpol) && !launch_q && !capture_q));

  // R6/R7: capture always coincides with an sck toggle
  assert_capture_on_edge_R6: assert property (@(posedge clk) disable iff (rst)
    capture_q |-> (sck_q != $past(sck_q)));

  // R8: latched mode stays put for the whole frame
  assert_mode_held_R8: assert property (@(posedge clk) disable iff (rst)
    (run_q && $past(run_q) && !rst) |-> $stable(mode_q));

endmodule

// File: rtl/spi_sck_gen.sv
module spi_sck_gen
  import sckp_pkg::*;
#(
  parameter int unsigned MOD_W    = 4,
  parameter int unsigned SLOW_DIV = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_active,
  input  logic             cfg_cpol,
  input  logic             cfg_cpha,
  input  logic             cfg_slow,
  input  logic [MOD_W-1:0] rate_mod,
  output logic             sck,
  output logic             launch_stb,
  output logic             capture_stb
);
  frame_mode_t      mode_in;
  logic             frame_start;
  logic             running;
  logic             edge_due;
  logic             slow_q;
  logic [MOD_W-1:0] mod_q;

  assign mode_in = '{cpol: cfg_cpol, cpha: cfg_cpha, slow: cfg_slow};

  // Rate settings are captured only when a frame opens (R8)
  always_ff @(posedge clk) begin
    if (rst) begin
      slow_q <= 1'b0;
      mod_q  <= '0;
    end else if (frame_start) begin
      slow_q <= cfg_slow;
      mod_q  <= rate_mod;
    end
  end

  sckp_rate_chain #(
    .MOD_W    (MOD_W),
    .SLOW_DIV (SLOW_DIV)
  ) i_chain (
    .clk      (clk),
    .rst      (rst),
    .clear    (frame_start | ~frame_active),
    .advance  (running & frame_active),
    .slow     (slow_q),
    .mod_lim  (mod_q),
    .edge_due (edge_due)
  );

  sckp_edge_seq i_seq (
    .clk          (clk),
    .rst          (rst),
    .frame_active (frame_active),
    .mode_in      (mode_in),
    .edge_due     (edge_due),
    .frame_start  (frame_start),
    .running      (running),
    .sck          (sck),
    .launch_stb   (launch_stb),
    .capture_stb  (capture_stb)
  );

  // R8: rate settings stay frozen inside a frame
  assert_rate_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    (running && !frame_start && $past(running)) |-> ($stable(mod_q) && $stable(slow_q)));

endmodule

// File: tb/test_spi_sck_gen.sv
module test_spi_sck_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       frame_active = 1'b0;
  logic       cfg_cpol = 1'b0;
  logic       cfg_cpha = 1'b0;
  logic       cfg_slow = 1'b0;
  logic [3:0] rate_mod = 4'd0;
  logic       sck, launch_stb, capture_stb;

  always #10 clk = ~clk;

  spi_sck_gen i_spi_sck_gen (
    .clk(clk), .rst(rst), .frame_active(frame_active),
    .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_slow(cfg_slow),
    .rate_mod(rate_mod), .sck(sck), .launch_stb(launch_stb),
    .capture_stb(capture_stb)
  );

  int    n_checks = 0;
  int    n_fail   = 0;
  string tag      = "R1";
  bit    done     = 0;

  // Behavioural reference model
  bit m_run, m_pol, m_pha, m_sck, m_l, m_c;
  int m_cnt, m_half, m_edges;

  always @(posedge clk) begin
    if (rst) begin
      m_run = 0; m_sck = 0; m_l = 0; m_c = 0;
    end else if (!frame_active) begin
      m_run = 0; m_sck = cfg_cpol; m_l = 0; m_c = 0;
    end else if (!m_run) begin
      m_run = 1; m_cnt = 0; m_edges = 0;
      m_half = 2 * (cfg_slow ? 16 : 1) * (int'(rate_mod) + 1);
      m_pol = cfg_cpol; m_pha = cfg_cpha;
      m_sck = cfg_cpol; m_l = !cfg_cpha; m_c = 0;
    end else begin
      m_cnt++; m_l = 0; m_c = 0;
      if (m_cnt % m_half == 0) begin
        m_sck = !m_sck;
        m_edges++;
        if (m_edges % 2 == 1) begin
          if (m_pha) m_l = 1; else m_c = 1;
        end else begin
          if (m_pha) m_c = 1; else m_l = 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      n_checks++;
      if (sck !== m_sck || launch_stb !== m_l || capture_stb !== m_c) begin
        n_fail++;
        $display("FAIL %s t=%0t actual sck/l/c=%b%b%b expected=%b%b%b",
                 tag, $time, sck, launch_stb, capture_stb, m_sck, m_l, m_c);
      end
    end
  end

  task automatic idle(input int n);
    frame_active = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input bit pol, input bit pha, input bit slow,
                       input int pm, input int len);
    cfg_cpol = pol; cfg_cpha = pha; cfg_slow = slow; rate_mod = 4'(pm);
    frame_active = 1'b1;
    repeat (len) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tag = "R1";
    rst = 1'b0;
    @(negedge clk);
    tag = "R2"; cfg_cpol = 1'b1; idle(4); cfg_cpol = 1'b0; idle(4);
    tag = "R3"; frame(0, 0, 0, 2, 60); idle(5);
    tag = "R3"; frame(1, 0, 0, 5, 80); idle(5);
    tag = "R4"; frame(0, 1, 1, 1, 300); idle(5);
    tag = "R5"; frame(1, 1, 0, 0, 20); idle(3);
    tag = "R5"; frame(0, 0, 1, 15, 1100); idle(3);
    tag = "R5"; frame(0, 1, 0, 15, 200); idle(3);
    tag = "R6"; frame(1, 0, 0, 3, 100); idle(4);
    tag = "R7"; frame(1, 1, 0, 3, 100); idle(4);
    // R8: change every setting mid-frame; the frame keeps its old settings
    tag = "R8"; frame(0, 0, 0, 1, 21);
    cfg_cpol = 1; cfg_cpha = 1; cfg_slow = 1; rate_mod = 4'd7;
    repeat (40) @(negedge clk);
    idle(3);
    tag = "R8"; frame(1, 1, 0, 2, 50); idle(3);
    // R9: stop in the middle of a half period, then restart at once
    tag = "R9"; frame(0, 0, 0, 4, 15);
    idle(1);
    frame(0, 0, 0, 4, 40);
    tag = "R9"; frame(1, 1, 0, 6, 23); idle(2);
    // R10: fastest rate, back-to-back strobes on alternate cycles
    tag = "R10"; frame(0, 1, 0, 0, 30); idle(4);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog %s expired", tag);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule